// File: doc/BRIEF.md
# Single-channel DMA cell/block copy engine

This block is one DMA channel that copies bytes from a source buffer to a destination buffer through a plain memory read port and a plain memory write port. Software programs a source base, a destination base, a source size, a destination size and a cell size through a small register port. It then sets the channel enable. Each start event, which is either the external start input or a software force bit, moves one cell and then leaves the channel waiting. The channel keeps taking events until a whole block has moved. At that point it raises a block-complete flag and drops its own enable.

The block length is the larger of the two buffer sizes. The source pointer and the destination pointer each wrap back to their own base when they reach their own size, so a short buffer is read or filled repeatedly. Each transaction is one read followed, on the next cycle, by one write of up to four bytes. A transaction is narrowed so that it never crosses a wrap point, the end of a cell or the end of the block. An abort input stops the channel at once and rewinds it.

Register map (3-bit register address, 32-bit data):

| Address | Register | Fields |
|---|---|---|
| 0 | control | bit 7 = enable |
| 1 | event | bit 7 = force (write only), bit 4 = start-input enable, bit 5 = abort-input enable |
| 2 | flags | bit 3 = block done, bit 2 = cell done, bit 1 = aborted |
| 3 | source base | |
| 4 | destination base | |
| 5 | source size | 8 bits |
| 6 | destination size | 8 bits |
| 7 | cell size | 8 bits |

Top module: `dma_cell_top`

## Requirements
- R1: After reset all eight registers read 0 and neither memory strobe is asserted.
- R2: A transaction asserts memRdEn with memRdAddr = source base + source pointer. The read port returns byte address+i on lane i one cycle later. In the next cycle memWrEn is asserted with memWrAddr = destination base + destination pointer, memWrData equal to the returned word, and memWrBe holding the low n bits set. Here n = min(4, bytes left in the cell, bytes to the source wrap, bytes to the destination wrap).
- R3: While enabled and idle, a start (the startEvt input with event bit 4 set, or a write of event bit 7) moves exactly one cell. It then sets flags bit 2, keeps the enable at 1 and waits for the next start.
- R4: The block size is max(source size, destination size). When that many bytes have moved, flags bits 3 and 2 set and the control enable bit clears.
- R5: A cell moves min(cell size, bytes left in the block). A cell size larger than the block therefore completes the block in one start.
- R6: The source and destination pointers each return to 0 independently when they reach their own size.
- R7: A size register value of 0 stands for 256 bytes.
- R8: While enabled, abortEvt with event bit 5 set clears the enable and sets flags bit 1. It stops memory access at once. It also rewinds both pointers and the block count, so the next block starts at the bases.
- R9: Writes to the base and size registers (addresses 3 to 7) are ignored while the channel is enabled.
- R10: Start inputs and force writes have no effect while the channel is disabled. startEvt also has no effect when event bit 4 is clear.
- R11: Writing 1 to a flags bit clears that bit and leaves the other flags bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWData | input | REG_W | Register write data |
| regRData | output | REG_W | Register read data for regAddr (combinational) |
| startEvt | input | 1 | Start event, one cell per accepted cycle |
| abortEvt | input | 1 | Abort event |
| memRdEn | output | 1 | Memory read strobe |
| memRdAddr | output | ADDR_W | Memory read byte address |
| memRdData | input | 32 | Read word, valid the cycle after memRdEn |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | ADDR_W | Memory write byte address |
| memWrData | output | 32 | Write word, lane i goes to address+i |
| memWrBe | output | 4 | Byte enables for the write lanes |

## Verification
The bench uses the defaults ADDR_W = 16, SIZE_W = 8 and REG_W = 32. With 8-bit size registers, the 0-means-256 encoding and a full 256-byte block fit easily inside a short run. The small odd sizes (12 against 8, 5 against 3) force wraps in the middle of a word, partial byte enables and cells cut short by the block end. A scoreboard checks every write's address, byte enables and data against a reference built from the requirements. Separate checks cover the abort rewind, the ignored starts and the configuration locked while the channel is enabled.

// File: rtl/dma_cell_pkg.sv
package dma_cell_pkg;
  localparam int WORD_BYTES = 4;

  localparam logic [2:0] REG_CTRL      = 3'd0;
  localparam logic [2:0] REG_EVT       = 3'd1;
  localparam logic [2:0] REG_FLAGS     = 3'd2;
  localparam logic [2:0] REG_SRC_BASE  = 3'd3;
  localparam logic [2:0] REG_DST_BASE  = 3'd4;
  localparam logic [2:0] REG_SRC_SIZE  = 3'd5;
  localparam logic [2:0] REG_DST_SIZE  = 3'd6;
  localparam logic [2:0] REG_CELL_SIZE = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCell;
    logic doRead;
    logic doWrite;
    logic clearAll;
  } dpStrobe_t;
endpackage

// File: rtl/dma_cell_dpath.sv
module dma_cell_dpath
  import dma_cell_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int REG_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWr,
  input  logic [2:0]              regAddr,
  input  logic [REG_W-1:0]        regWData,
  input  logic                    chanOn,
  input  dpStrobe_t               strobe,
  input  logic [WORD_BYTES*8-1:0] memRdData,
  output logic [ADDR_W-1:0]       memRdAddr,
  output logic [ADDR_W-1:0]       memWrAddr,
  output logic [WORD_BYTES*8-1:0] memWrData,
  output logic [WORD_BYTES-1:0]   memWrBe,
  output logic                    lastCell,
  output logic                    lastBlock,
  output logic [REG_W-1:0]        cfgRData
);
  localparam int CNT_W = SIZE_W + 1;
  localparam int NB_W  = $clog2(WORD_BYTES + 1);

  logic [ADDR_W-1:0] srcBase, dstBase;
  logic [SIZE_W-1:0] srcSizeR, dstSizeR, cellSizeR;
  logic [CNT_W-1:0]  srcPtr, dstPtr, moved, cellLeft;
  logic [CNT_W-1:0]  srcSz, dstSz, cellSz, blockSz;
  logic [CNT_W-1:0]  blkLeft, chunk, srcNext, dstNext;
  logic [NB_W-1:0]   txnBytes;
  logic              unusedWBits;

  function automatic logic [CNT_W-1:0] decodeSize(input logic [SIZE_W-1:0] raw);
    return (raw == '0) ? (CNT_W'(1) << SIZE_W) : CNT_W'(raw);
  endfunction

  function automatic logic [CNT_W-1:0] minOf(input logic [CNT_W-1:0] a,
                                             input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  assign unusedWBits = ^regWData[REG_W-1:ADDR_W];

  assign srcSz   = decodeSize(srcSizeR);
  assign dstSz   = decodeSize(dstSizeR);
  assign cellSz  = decodeSize(cellSizeR);
  assign blockSz = (srcSz > dstSz) ? srcSz : dstSz;
  assign blkLeft = blockSz - moved;

  // transaction width: word, cell remainder and both wrap distances
  assign chunk = minOf(minOf(CNT_W'(WORD_BYTES), cellLeft),
                       minOf(srcSz - srcPtr, dstSz - dstPtr));
  assign txnBytes = chunk[NB_W-1:0];

  assign srcNext = srcPtr + chunk;
  assign dstNext = dstPtr + chunk;

  assign lastCell  = (cellLeft == chunk);
  assign lastBlock = ((moved + chunk) == blockSz);

  assign memRdAddr = srcBase + ADDR_W'(srcPtr);
  assign memWrAddr = dstBase + ADDR_W'(dstPtr);
  assign memWrData = memRdData;

  always_comb begin
    for (int i = 0; i < WORD_BYTES; i++) begin
      memWrBe[i] = (NB_W'(i) < txnBytes);
    end
  end

  // configuration, locked while the channel runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcBase   <= '0;
      dstBase   <= '0;
      srcSizeR  <= '0;
      dstSizeR  <= '0;
      cellSizeR <= '0;
    end else if (regWr && !chanOn) begin
      case (regAddr)
        REG_SRC_BASE:  srcBase   <= regWData[ADDR_W-1:0];
        REG_DST_BASE:  dstBase   <= regWData[ADDR_W-1:0];
        REG_SRC_SIZE:  srcSizeR  <= regWData[SIZE_W-1:0];
        REG_DST_SIZE:  dstSizeR  <= regWData[SIZE_W-1:0];
        REG_CELL_SIZE: cellSizeR <= regWData[SIZE_W-1:0];
        default: ;
      endcase
    end
  end

  // pointers and counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPtr   <= '0;
      dstPtr   <= '0;
      moved    <= '0;
      cellLeft <= '0;
    end else if (strobe.clearAll) begin
      srcPtr   <= '0;
      dstPtr   <= '0;
      moved    <= '0;
      cellLeft <= '0;
    end else if (strobe.loadCell) begin
      cellLeft <= minOf(cellSz, blkLeft);
    end else if (strobe.doWrite) begin
      srcPtr   <= (srcNext == srcSz) ? '0 : srcNext;
      dstPtr   <= (dstNext == dstSz) ? '0 : dstNext;
      moved    <= moved + chunk;
      cellLeft <= cellLeft - chunk;
    end
  end

  always_comb begin
    case (regAddr)
      REG_SRC_BASE:  cfgRData = REG_W'(srcBase);
      REG_DST_BASE:  cfgRData = REG_W'(dstBase);
      REG_SRC_SIZE:  cfgRData = REG_W'(srcSizeR);
      REG_DST_SIZE:  cfgRData = REG_W'(dstSizeR);
      REG_CELL_SIZE: cfgRData = REG_W'(cellSizeR);
      default:       cfgRData = '0;
    endcase
  end
endmodule

// File: rtl/dma_cell_ctrl.sv
module dma_cell_ctrl
  import dma_cell_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [2:0]       regAddr,
  input  logic [REG_W-1:0] regWData,
  input  logic             startEvt,
  input  logic             abortEvt,
  input  logic             lastCell,
  input  logic             lastBlock,
  output dpStrobe_t        strobe,
  output logic             chanOn,
  output logic [1:0]       evtEn,
  output logic [2:0]       flags
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_e;

  state_e     stateQ, stateNext;
  logic       chanNext;
  logic [2:0] flagSet, flagClr;
  logic       ctrlWr, evtWr, flagWr;
  logic       forceStart, startReq, abortReq, enableReq, disableReq;
  logic       unusedWBits;

  assign unusedWBits = ^{regWData[REG_W-1:8], regWData[6], regWData[0]};

  assign ctrlWr = regWr && (regAddr == REG_CTRL);
  assign evtWr  = regWr && (regAddr == REG_EVT);
  assign flagWr = regWr && (regAddr == REG_FLAGS);

  assign forceStart = evtWr && regWData[7];
  assign startReq   = chanOn && (forceStart || (startEvt && evtEn[0]));
  assign abortReq   = chanOn && abortEvt && evtEn[1];
  assign enableReq  = ctrlWr && regWData[7] && !chanOn;
  assign disableReq = ctrlWr && !regWData[7] && chanOn;

  always_comb begin
    strobe    = '0;
    stateNext = stateQ;
    chanNext  = chanOn;
    flagSet   = '0;
    flagClr   = flagWr ? regWData[3:1] : 3'b000;
    if (abortReq || disableReq) begin
      strobe.clearAll = 1'b1;
      stateNext       = ST_IDLE;
      chanNext        = 1'b0;
      flagSet[0]      = abortReq;
    end else begin
      if (enableReq) chanNext = 1'b1;
      case (stateQ)
        ST_IDLE: begin
          if (startReq) begin
            strobe.loadCell = 1'b1;
            stateNext       = ST_READ;
          end
        end
        ST_READ: begin
          strobe.doRead = 1'b1;
          stateNext     = ST_WRITE;
        end
        ST_WRITE: begin
          strobe.doWrite = 1'b1;
          if (lastBlock) begin
            strobe.clearAll = 1'b1;
            chanNext        = 1'b0;
            flagSet         = 3'b110;
            stateNext       = ST_IDLE;
          end else if (lastCell) begin
            flagSet   = 3'b010;
            stateNext = ST_IDLE;
          end else begin
            stateNext = ST_READ;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      chanOn <= 1'b0;
      evtEn  <= 2'b00;
      flags  <= 3'b000;
    end else begin
      stateQ <= stateNext;
      chanOn <= chanNext;
      if (evtWr) evtEn <= {regWData[5], regWData[4]};
      flags <= (flags & ~flagClr) | flagSet;
    end
  end
endmodule

// File: rtl/dma_cell_top.sv
module dma_cell_top
  import dma_cell_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWData,
  output logic [REG_W-1:0]  regRData,
  input  logic              startEvt,
  input  logic              abortEvt,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [31:0]       memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [3:0]        memWrBe
);
  dpStrobe_t        strobe;
  logic             chanOn, lastCell, lastBlock;
  logic [1:0]       evtEn;
  logic [2:0]       flags;
  logic [REG_W-1:0] cfgRData;

  dma_cell_ctrl #(.REG_W(REG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWData(regWData),
    .startEvt(startEvt), .abortEvt(abortEvt), .lastCell(lastCell), .lastBlock(lastBlock),
    .strobe(strobe), .chanOn(chanOn), .evtEn(evtEn), .flags(flags)
  );

  dma_cell_dpath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .REG_W(REG_W)) dpath_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWData(regWData),
    .chanOn(chanOn), .strobe(strobe), .memRdData(memRdData),
    .memRdAddr(memRdAddr), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrBe(memWrBe), .lastCell(lastCell), .lastBlock(lastBlock), .cfgRData(cfgRData)
  );

  assign memRdEn = strobe.doRead;
  assign memWrEn = strobe.doWrite;

  always_comb begin
    case (regAddr)
      REG_CTRL:  regRData = REG_W'({chanOn, 7'b0});
      REG_EVT:   regRData = REG_W'({evtEn, 4'b0});
      REG_FLAGS: regRData = REG_W'({flags, 1'b0});
      default:   regRData = cfgRData;
    endcase
  end
endmodule

// File: rtl/dma_cell_chk.sv
module dma_cell_chk (
  input logic       clk,
  input logic       rstN,
  input logic       memRdEn,
  input logic       memWrEn,
  input logic [3:0] memWrBe,
  input logic       abortEvt,
  input logic       chanOn,
  input logic       abortEn,
  input logic [2:0] flags
);
  // R2: every write is the second half of a read/write pair
  p_wr_follows_rd_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(memRdEn));

  // R2: byte enables are a contiguous run from lane 0
  p_be_contig_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrBe == 4'b0001 || memWrBe == 4'b0011 ||
                 memWrBe == 4'b0111 || memWrBe == 4'b1111));

  // R10: a disabled channel touches no memory
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !chanOn |-> (!memRdEn && !memWrEn));

  // R4: block completion drops the enable
  p_block_disables_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[2]) |-> !chanOn);

  // R8: accepted abort disables and flags
  p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    (chanOn && abortEvt && abortEn) |=> (!chanOn && flags[0]));

  // R8: no write in an abort cycle
  p_abort_no_wr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (chanOn && abortEvt && abortEn) |-> !memWrEn);
endmodule

bind dma_cell_top dma_cell_chk chk_i (
  .clk(clk), .rstN(rstN), .memRdEn(memRdEn), .memWrEn(memWrEn), .memWrBe(memWrBe),
  .abortEvt(abortEvt), .chanOn(chanOn), .abortEn(evtEn[1]), .flags(flags)
);

// File: tb/dma_cell_top_tb_top.sv
`timescale 1ns/1ps
module dma_cell_top_tb_top;
  localparam int ADDR_W = 16;
  localparam int REG_W  = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWr = 1'b0;
  logic [2:0]        regAddr = '0;
  logic [REG_W-1:0]  regWData = '0;
  logic [REG_W-1:0]  regRData;
  logic              startEvt = 1'b0;
  logic              abortEvt = 1'b0;
  logic              memRdEn, memWrEn;
  logic [ADDR_W-1:0] memRdAddr, memWrAddr;
  logic [31:0]       memRdData = '0;
  logic [31:0]       memWrData;
  logic [3:0]        memWrBe;

  always #2 clk = ~clk;

  dma_cell_top dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWData(regWData),
    .regRData(regRData), .startEvt(startEvt), .abortEvt(abortEvt),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrBe(memWrBe)
  );

  // memory model
  logic [7:0] mem [0:4095];
  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13 + 5) & 255);
  endfunction
  initial for (int i = 0; i < 4096; i++) mem[i] = pat(i);

  always @(posedge clk) begin
    if (memRdEn)
      memRdData <= {mem[12'(memRdAddr + 3)], mem[12'(memRdAddr + 2)],
                    mem[12'(memRdAddr + 1)], mem[12'(memRdAddr)]};
    if (memWrEn)
      for (int i = 0; i < 4; i++)
        if (memWrBe[i]) mem[12'(memWrAddr + i)] <= memWrData[8*i +: 8];
  end

  // scoreboard
  typedef struct packed {
    logic [15:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
  } wrItem_t;
  wrItem_t expQ [$];

  int checks = 0, fails = 0, rdCount = 0;
  bit sbOn = 1'b1, done = 1'b0;
  bit grabFirst = 1'b0;
  logic [15:0] firstRdAddr = '0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (memRdEn) begin
        rdCount++;
        if (grabFirst) begin firstRdAddr = memRdAddr; grabFirst = 1'b0; end
      end
      if (memWrEn && sbOn) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected write", longint'(memWrAddr), 0);
        end else begin
          wrItem_t e;
          wrItem_t a;
          e = expQ.pop_front();
          a = '{addr: memWrAddr, be: memWrBe, data: memWrData};
          check(a == e, "R2 R6 write addr/be/data", longint'(a), longint'(e));
        end
      end
    end
  end

  // reference model
  int mSB, mDB, mSS, mDS, mCS, mS, mD, mMoved;
  task automatic modelCfg(input int sb, input int db, input int ss, input int ds, input int cs);
    mSB = sb; mDB = db;
    mSS = (ss == 0) ? 256 : ss;
    mDS = (ds == 0) ? 256 : ds;
    mCS = (cs == 0) ? 256 : cs;
    mS = 0; mD = 0; mMoved = 0;
  endtask
  task automatic modelCell();
    int blk, left, n, sa;
    wrItem_t it;
    blk  = (mSS > mDS) ? mSS : mDS;
    left = (mCS < blk - mMoved) ? mCS : blk - mMoved;
    while (left > 0) begin
      n = 4;
      if (left < n) n = left;
      if (mSS - mS < n) n = mSS - mS;
      if (mDS - mD < n) n = mDS - mD;
      sa = mSB + mS;
      it.addr = 16'(mDB + mD);
      it.be   = 4'((1 << n) - 1);
      it.data = {pat(sa + 3), pat(sa + 2), pat(sa + 1), pat(sa)};
      expQ.push_back(it);
      mS += n; mD += n; mMoved += n; left -= n;
      if (mS == mSS) mS = 0;
      if (mD == mDS) mD = 0;
    end
    if (mMoved == blk) begin mS = 0; mD = 0; mMoved = 0; end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask
  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRData;
  endtask
  task automatic pulse(input bit isAbort);
    @(negedge clk);
    if (isAbort) abortEvt = 1'b1; else startEvt = 1'b1;
    @(negedge clk);
    abortEvt = 1'b0; startEvt = 1'b0;
  endtask
  task automatic waitFlag(input logic [31:0] mask, input string tag);
    logic [31:0] d;
    int n;
    n = 0;
    d = '0;
    while ((d & mask) == 0 && n < 3000) begin regRead(3'd2, d); n++; end
    if (n >= 3000) check(1'b0, tag, longint'(d), longint'(mask));
  endtask
  task automatic configure(input int sb, input int db, input int ss, input int ds, input int cs);
    regWrite(3'd3, 32'(sb)); regWrite(3'd4, 32'(db));
    regWrite(3'd5, 32'(ss)); regWrite(3'd6, 32'(ds)); regWrite(3'd7, 32'(cs));
    modelCfg(sb, db, ss, ds, cs);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 0);
      report();
    end
  end

  initial begin
    logic [31:0] d;
    int rc;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      regRead(3'(a), d);
      check(d == 0, "R1 register reset value", longint'(d), 0);
    end
    check(rdCount == 0, "R1 no memory reads after reset", rdCount, 0);

    // main block: sizes 12/8, cell 6 -> two cells, mid-word destination wrap
    configure(16'h100, 16'h200, 12, 8, 6);
    regRead(3'd5, d);
    check(d == 12, "R9 size writable while disabled", longint'(d), 12);
    regWrite(3'd1, 32'h30);
    regWrite(3'd0, 32'h80);
    regWrite(3'd3, 32'h777);
    regWrite(3'd5, 32'd40);
    regRead(3'd3, d);
    check(d == 32'h100, "R9 base write ignored while enabled", longint'(d), 32'h100);
    regRead(3'd5, d);
    check(d == 12, "R9 size write ignored while enabled", longint'(d), 12);

    modelCell();
    regWrite(3'd1, 32'hB0);
    waitFlag(32'h4, "R3 cell flag timeout");
    repeat (3) @(negedge clk);
    regRead(3'd2, d);
    check(d == 32'h4, "R3 only cell flag after first cell", longint'(d), 32'h4);
    regRead(3'd0, d);
    check(d == 32'h80, "R3 enable kept between cells", longint'(d), 32'h80);
    check(expQ.size() == 0, "R3 first cell writes complete", expQ.size(), 0);
    regWrite(3'd2, 32'h4);
    regRead(3'd2, d);
    check(d == 0, "R11 cell flag cleared", longint'(d), 0);

    modelCell();
    pulse(1'b0);
    waitFlag(32'h8, "R4 block flag timeout");
    regRead(3'd2, d);
    check(d == 32'hC, "R4 block and cell flags", longint'(d), 32'hC);
    regRead(3'd0, d);
    check(d == 0, "R4 enable cleared at block end", longint'(d), 0);
    check(expQ.size() == 0, "R6 block writes complete", expQ.size(), 0);
    regWrite(3'd2, 32'h8);
    regRead(3'd2, d);
    check(d == 32'h4, "R11 only block flag cleared", longint'(d), 32'h4);
    regWrite(3'd2, 32'hE);

    // R10 starts while disabled / with start input masked
    rc = rdCount;
    pulse(1'b0);
    regWrite(3'd1, 32'hB0);
    repeat (20) @(negedge clk);
    check(rdCount == rc, "R10 start ignored while disabled", rdCount, rc);
    regWrite(3'd1, 32'h00);
    regWrite(3'd0, 32'h80);
    pulse(1'b0);
    repeat (20) @(negedge clk);
    check(rdCount == rc, "R10 start ignored when input masked", rdCount, rc);
    regRead(3'd2, d);
    check(d == 0, "R10 no flags from masked start", longint'(d), 0);
    regWrite(3'd0, 32'h00);

    // R5: cell 20 beyond block of 5 (sizes 5/3)
    configure(16'h300, 16'h380, 5, 3, 20);
    regWrite(3'd1, 32'h10);
    regWrite(3'd0, 32'h80);
    modelCell();
    pulse(1'b0);
    waitFlag(32'h8, "R5 block flag timeout");
    regRead(3'd2, d);
    check(d == 32'hC, "R5 one start finishes block", longint'(d), 32'hC);
    check(expQ.size() == 0, "R5 capped cell writes complete", expQ.size(), 0);
    regWrite(3'd2, 32'hE);

    // R7: size code 0 is 256 bytes
    configure(16'h400, 16'h600, 0, 16, 0);
    regWrite(3'd0, 32'h80);
    modelCell();
    pulse(1'b0);
    waitFlag(32'h8, "R7 block flag timeout");
    regRead(3'd2, d);
    check(d == 32'hC, "R7 256-byte block in one start", longint'(d), 32'hC);
    check(expQ.size() == 0, "R7 256-byte writes complete", expQ.size(), 0);
    regWrite(3'd2, 32'hE);

    // R8 abort mid-cell, then restart from the bases
    configure(16'h800, 16'h900, 64, 64, 64);
    regWrite(3'd1, 32'h30);
    regWrite(3'd0, 32'h80);
    sbOn = 1'b0;
    regWrite(3'd1, 32'hB0);
    repeat (5) @(negedge clk);
    pulse(1'b1);
    regRead(3'd0, d);
    check(d == 0, "R8 abort clears enable", longint'(d), 0);
    regRead(3'd2, d);
    check(d == 32'h2, "R8 abort flag", longint'(d), 32'h2);
    rc = rdCount;
    repeat (20) @(negedge clk);
    check(rdCount == rc, "R8 no access after abort", rdCount, rc);
    regWrite(3'd2, 32'h2);
    regWrite(3'd7, 32'd8);
    modelCfg(16'h800, 16'h900, 64, 64, 8);
    regWrite(3'd0, 32'h80);
    modelCell();
    sbOn = 1'b1;
    grabFirst = 1'b1;
    regWrite(3'd1, 32'hB0);
    waitFlag(32'h4, "R8 restart cell timeout");
    check(firstRdAddr == 16'h800, "R8 restart reads from source base",
          longint'(firstRdAddr), 32'h800);
    check(expQ.size() == 0, "R8 restart writes from destination base", expQ.size(), 0);

    done = 1'b1;
    report();
  end
endmodule